// File: doc/BRIEF.md
# Serial Memory Page Write Collector and Commit Engine

This block sits behind the bus front-end of a byte-wide serial non-volatile memory. When a write session opens, the front-end hands it the byte address from the address phase. The block then collects each incoming data byte into a 16-slot page buffer. The page number stays fixed for the whole session. Only the four low address bits step forward from byte to byte, and they roll over inside the page.

A stop pulse ends the session. If any byte was collected and write protection was not active when the first data byte arrived, the block starts one internal write cycle of fixed length. During that cycle it moves the collected bytes into the storage array and holds `busy` high, which tells the front-end to refuse new address bytes. The storage array holds 1024 bytes by default, or 512 through a parameter. It is modelled as a register array that resets to all-ones, and it has a combinational observation port.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset `busy` is 0, no array write is issued, and every array location reads 8'hFF on `rdData`.
- R2: A session made of one address, one data byte and a stop stores that byte at the given address. All other locations keep their contents.
- R3: Bytes in a session land at consecutive addresses. Only the low 4 bits advance. After offset 15 the next byte goes to offset 0 of the same page, so a session starting at 0x2FE writes 0x2FE, 0x2FF, 0x2F0, 0x2F1 and leaves 0x300 untouched.
- R4: If more than 16 bytes are sent, a later byte replaces the earlier byte held at the same page offset.
- R5: Only the page offsets written in the session are committed. The other bytes of the page keep their old values, and the array write port issues exactly one write per written offset, in ascending offset order.
- R6: `busy` rises in the cycle after the clock edge that samples a committing stop. It stays high for exactly WRITE_CYCLES cycles.
- R7: While `busy` is high, `addrValid`, `dataValid` and `stopPulse` have no effect. No new session starts and the cycle length is unchanged.
- R8: If `wpLevel` is 1 on the clock edge that takes the first data byte, the session is rejected. No byte is stored, no array write is issued, and `busy` stays 0.
- R9: `wpLevel` is looked at only on the first data byte. Raising it on later bytes does not reject the session.
- R10: A stop that ends a session with no data byte (an address-only write) starts no write cycle.
- R11: The array write port is active only while `busy` is high, and only for addresses inside the session's page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addrValid | input | 1 | One-cycle strobe: address phase done, `startAddr` valid |
| startAddr | input | ADDR_W | Byte address latched at session start |
| dataValid | input | 1 | One-cycle strobe: one data byte received |
| dataByte | input | 8 | Data byte qualified by `dataValid` |
| stopPulse | input | 1 | One-cycle strobe: stop condition seen |
| wpLevel | input | 1 | Write-protect level, sampled on the first data byte |
| busy | output | 1 | Internal write cycle in progress |
| arrWrEn | output | 1 | Array write enable |
| arrWrAddr | output | ADDR_W | Array write address |
| arrWrData | output | 8 | Array write data |
| rdAddr | input | ADDR_W | Array observation address |
| rdData | output | 8 | Array contents at `rdAddr` (combinational) |

## Verification
The bench targets four cases. The first is the page wrap at offset 15: an engine that carried the offset into the page number would write 0x300 instead of 0x2F0. The second is a 17th and 18th byte: an engine that dropped extra bytes, or that committed stale ones, would leave the first two offsets holding the earlier values. The third is write-protect timing: an engine that sampled the level on every byte or at the stop would either commit a protected session or reject an open one. The fourth is traffic during the write cycle and address-only sessions: an engine that reacted to either would start a stray session, extend `busy`, or raise it with nothing to write. A scoreboard compares every array write against the modelled sequence, so a write to an unwritten offset shows up as an unexpected write.

// File: rtl/pw_pkg.sv
package pw_pkg;
  parameter int unsigned PW_PAGE_BYTES = 16;
  localparam int unsigned PW_OFF_W = $clog2(PW_PAGE_BYTES);

  typedef struct packed {
    logic                sessStart;
    logic                byteTake;
    logic                commitEn;
    logic [PW_OFF_W-1:0] commitIdx;
  } pw_strobe_t;
endpackage

// File: rtl/pw_ctrl.sv
module pw_ctrl
  import pw_pkg::*;
#(
  parameter int unsigned WRITE_CYCLES = 250000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       addrValid,
  input  logic       dataValid,
  input  logic       stopPulse,
  input  logic       wpLevel,
  input  logic       maskAny,
  output pw_strobe_t strb,
  output logic       busy
);
  localparam int unsigned CNT_W = $clog2(WRITE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WRITE_CYCLES - 1);
  localparam logic [CNT_W-1:0] CNT_PAGE = CNT_W'(PW_PAGE_BYTES);

  typedef enum logic [1:0] {S_IDLE, S_COLLECT, S_REJECT, S_BUSY} pw_state_e;

  pw_state_e        state, stateNext;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    stateNext = state;
    strb      = '0;
    unique case (state)
      S_IDLE: begin
        if (addrValid) begin
          strb.sessStart = 1'b1;
          stateNext      = S_COLLECT;
        end
      end
      S_COLLECT: begin
        if (stopPulse) begin
          stateNext = maskAny ? S_BUSY : S_IDLE;
        end else if (addrValid) begin
          strb.sessStart = 1'b1;
        end else if (dataValid) begin
          if (!maskAny && wpLevel) stateNext = S_REJECT;
          else                     strb.byteTake = 1'b1;
        end
      end
      S_REJECT: begin
        if (stopPulse) begin
          stateNext = S_IDLE;
        end else if (addrValid) begin
          strb.sessStart = 1'b1;
          stateNext      = S_COLLECT;
        end
      end
      S_BUSY: begin
        if (cnt == CNT_LAST) stateNext = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
    strb.commitEn  = (state == S_BUSY) && (cnt < CNT_PAGE);
    strb.commitIdx = cnt[PW_OFF_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNext;
      if (state == S_BUSY && cnt != CNT_LAST) cnt <= cnt + 1'b1;
      else                                   cnt <= '0;
    end
  end

  assign busy = (state == S_BUSY);

  assert_busy_after_stop_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_COLLECT && stopPulse && maskAny) |=> busy);

  assert_busy_length_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> ($past(cnt) == CNT_LAST));

  assert_no_session_while_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (!strb.sessStart && !strb.byteTake));

  assert_reject_stores_nothing_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_REJECT) |=> !maskAny);
endmodule

// File: rtl/pw_datapath.sv
module pw_datapath
  import pw_pkg::*;
#(
  parameter int unsigned MEM_DEPTH = 1024,
  localparam int unsigned ADDR_W = $clog2(MEM_DEPTH),
  localparam int unsigned PAGE_W = ADDR_W - PW_OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  pw_strobe_t        strb,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [7:0]        dataByte,
  output logic              maskAny,
  output logic              arrWrEn,
  output logic [ADDR_W-1:0] arrWrAddr,
  output logic [7:0]        arrWrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData
);
  logic [PAGE_W-1:0]        pageBase;
  logic [PW_OFF_W-1:0]      offset;
  logic [PW_PAGE_BYTES-1:0] slotValid;
  logic [7:0]               slotData [PW_PAGE_BYTES];
  logic [7:0]               mem [MEM_DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageBase <= '0;
      offset   <= '0;
    end else if (strb.sessStart) begin
      pageBase <= startAddr[ADDR_W-1:PW_OFF_W];
      offset   <= startAddr[PW_OFF_W-1:0];
    end else if (strb.byteTake) begin
      offset <= offset + 1'b1;
    end
  end

  for (genvar i = 0; i < PW_PAGE_BYTES; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotValid[i] <= 1'b0;
        slotData[i]  <= '0;
      end else if (strb.sessStart) begin
        slotValid[i] <= 1'b0;
      end else if (strb.byteTake && offset == PW_OFF_W'(i)) begin
        slotValid[i] <= 1'b1;
        slotData[i]  <= dataByte;
      end
    end
  end

  assign maskAny   = |slotValid;
  assign arrWrEn   = strb.commitEn && slotValid[strb.commitIdx];
  assign arrWrAddr = {pageBase, strb.commitIdx};
  assign arrWrData = slotData[strb.commitIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < MEM_DEPTH; k++) mem[k] <= 8'hFF;
    end else if (arrWrEn) begin
      mem[arrWrAddr] <= arrWrData;
    end
  end

  assign rdData = mem[rdAddr];

  assert_offset_steps_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.byteTake && !strb.sessStart) |=> (offset == $past(offset) + 1'b1));

  assert_mask_cleared_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.sessStart |=> !maskAny);

  assert_page_held_in_commit_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commitEn && $past(strb.commitEn)) |-> $stable(pageBase));
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
  import pw_pkg::*;
#(
  parameter int unsigned MEM_DEPTH    = 1024,
  parameter int unsigned WRITE_CYCLES = 250000,
  localparam int unsigned ADDR_W = $clog2(MEM_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrValid,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              dataValid,
  input  logic [7:0]        dataByte,
  input  logic              stopPulse,
  input  logic              wpLevel,
  output logic              busy,
  output logic              arrWrEn,
  output logic [ADDR_W-1:0] arrWrAddr,
  output logic [7:0]        arrWrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData
);
  pw_strobe_t strb;
  logic       maskAny;

  pw_ctrl #(.WRITE_CYCLES(WRITE_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .addrValid(addrValid), .dataValid(dataValid),
    .stopPulse(stopPulse), .wpLevel(wpLevel), .maskAny(maskAny),
    .strb(strb), .busy(busy)
  );

  pw_datapath #(.MEM_DEPTH(MEM_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .startAddr(startAddr),
    .dataByte(dataByte), .maskAny(maskAny), .arrWrEn(arrWrEn),
    .arrWrAddr(arrWrAddr), .arrWrData(arrWrData), .rdAddr(rdAddr),
    .rdData(rdData)
  );

  assert_write_only_busy_R11: assert property (@(posedge clk) disable iff (!rstN)
    arrWrEn |-> busy);

  assert_busy_needs_stop_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(stopPulse));
endmodule

// File: tb/eeprom_page_writer_tb.sv
module eeprom_page_writer_tb;
  localparam int DEPTH = 1024;
  localparam int AW    = 10;
  localparam int WC    = 40;

  logic          clk = 1'b0;
  logic          rstN;
  logic          addrValid, dataValid, stopPulse, wpLevel;
  logic [AW-1:0] startAddr, rdAddr;
  logic [7:0]    dataByte;
  logic          busy, arrWrEn;
  logic [AW-1:0] arrWrAddr;
  logic [7:0]    arrWrData, rdData;

  int checks = 0;
  int failures = 0;

  logic [AW+7:0] expQ [$];
  logic [7:0]    shadow [DEPTH];
  logic [7:0]    pgBuf [16];
  logic [15:0]   pgMask;
  logic [AW-1:0] sessAddr;
  logic [3:0]    sessOff;
  logic          sessRej;

  always #10 clk = ~clk;

  eeprom_page_writer #(.MEM_DEPTH(DEPTH), .WRITE_CYCLES(WC)) u_dut (
    .clk(clk), .rstN(rstN), .addrValid(addrValid), .startAddr(startAddr),
    .dataValid(dataValid), .dataByte(dataByte), .stopPulse(stopPulse),
    .wpLevel(wpLevel), .busy(busy), .arrWrEn(arrWrEn), .arrWrAddr(arrWrAddr),
    .arrWrData(arrWrData), .rdAddr(rdAddr), .rdData(rdData)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: every array write must match the next expected item.
  always @(negedge clk) begin
    if (rstN && arrWrEn) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R5 unexpected write", int'({arrWrAddr, arrWrData}), 0);
      end else begin
        logic [AW+7:0] e;
        e = expQ.pop_front();
        check({arrWrAddr, arrWrData} == e, "R5 write port", int'({arrWrAddr, arrWrData}), int'(e));
      end
    end
  end

  task automatic rawCycle(input bit a, input logic [AW-1:0] ad, input bit d,
                          input logic [7:0] db, input bit s);
    addrValid = a; startAddr = ad; dataValid = d; dataByte = db; stopPulse = s;
    @(negedge clk);
    addrValid = 0; dataValid = 0; stopPulse = 0;
  endtask

  task automatic openSess(input logic [AW-1:0] ad);
    sessAddr = ad; sessOff = ad[3:0]; pgMask = '0; sessRej = 0;
    rawCycle(1, ad, 0, 8'h00, 0);
  endtask

  task automatic sendByte(input logic [7:0] d);
    if (pgMask == 0 && wpLevel) sessRej = 1;
    if (!sessRej) begin
      pgBuf[sessOff] = d; pgMask[sessOff] = 1'b1; sessOff = sessOff + 1'b1;
    end
    rawCycle(0, '0, 1, d, 0);
  endtask

  task automatic readCheck(input logic [AW-1:0] ad, input string req);
    rdAddr = ad;
    #1;
    check(rdData == shadow[ad], req, int'(rdData), int'(shadow[ad]));
  endtask

  // Ends the session; with intrude set, drives a full session during busy (R7).
  task automatic closeSess(input bit intrude, input string req);
    bit commit;
    int n;
    commit = (pgMask != 0) && !sessRej;
    if (commit) begin
      for (int i = 0; i < 16; i++)
        if (pgMask[i]) begin
          expQ.push_back({sessAddr[AW-1:4], 4'(i), pgBuf[i]});
          shadow[{sessAddr[AW-1:4], 4'(i)}] = pgBuf[i];
        end
    end
    rawCycle(0, '0, 0, 8'h00, 1);
    n = 0;
    if (commit) begin
      if (intrude) begin
        rawCycle(1, 10'h200, 0, 8'h00, 0); n++;
        rawCycle(0, '0, 1, 8'hC3, 0);      n++;
        rawCycle(0, '0, 1, 8'hC4, 0);      n++;
        rawCycle(0, '0, 0, 8'h00, 1);      n++;
      end
      while (busy && n < WC + 20) begin
        n++;
        @(negedge clk);
      end
      check(n == WC, req, n, WC);
    end else begin
      for (int i = 0; i < 4; i++) begin
        if (busy) n++;
        @(negedge clk);
      end
      check(n == 0, req, n, 0);
    end
    check(expQ.size() == 0, "R5 queue drained", expQ.size(), 0);
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) shadow[i] = 8'hFF;
    rstN = 0; addrValid = 0; dataValid = 0; stopPulse = 0; wpLevel = 0;
    startAddr = '0; dataByte = '0; rdAddr = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    check(busy == 0, "R1 busy", busy, 0);
    check(arrWrEn == 0, "R1 wren", arrWrEn, 0);
    readCheck(10'h000, "R1 erased");
    readCheck(10'h3FF, "R1 erased");

    // R2 single byte, R6 busy length
    openSess(10'h123); sendByte(8'hA5); closeSess(0, "R6 busy length");
    readCheck(10'h123, "R2 byte stored");
    readCheck(10'h122, "R2 neighbour");
    readCheck(10'h124, "R2 neighbour");

    // R3 wrap inside page
    openSess(10'h2FE);
    sendByte(8'h11); sendByte(8'h22); sendByte(8'h33); sendByte(8'h44);
    closeSess(0, "R6 busy length");
    readCheck(10'h2FE, "R3 wrap");
    readCheck(10'h2FF, "R3 wrap");
    readCheck(10'h2F0, "R3 wrap");
    readCheck(10'h2F1, "R3 wrap");
    readCheck(10'h300, "R3 no carry");

    // R4 overwrite after 16 bytes
    openSess(10'h040);
    for (int i = 0; i < 18; i++) sendByte(8'(i * 3 + 1));
    closeSess(0, "R6 busy length");
    readCheck(10'h040, "R4 overwrite");
    readCheck(10'h041, "R4 overwrite");
    readCheck(10'h042, "R4 kept");
    readCheck(10'h04F, "R4 kept");

    // R5 partial page keeps other bytes
    openSess(10'h125); sendByte(8'h5A); closeSess(0, "R6 busy length");
    readCheck(10'h123, "R5 untouched");
    readCheck(10'h125, "R5 written");

    // R8 write protect at first byte
    wpLevel = 1;
    openSess(10'h010); sendByte(8'h77);
    wpLevel = 0;
    sendByte(8'h78);
    closeSess(0, "R8 no busy");
    readCheck(10'h010, "R8 protected");
    readCheck(10'h011, "R8 protected");

    // R9 wp raised after first byte is ignored
    openSess(10'h080); sendByte(8'h90);
    wpLevel = 1;
    sendByte(8'h91);
    closeSess(0, "R9 busy length");
    wpLevel = 0;
    readCheck(10'h080, "R9 committed");
    readCheck(10'h081, "R9 committed");

    // R10 address-only session
    openSess(10'h0A0); closeSess(0, "R10 no busy");

    // R7 traffic while busy ignored
    openSess(10'h1F3); sendByte(8'hE1); closeSess(1, "R7 busy length");
    readCheck(10'h1F3, "R7 committed");
    readCheck(10'h200, "R7 ignored");
    readCheck(10'h201, "R7 ignored");
    repeat (3) @(negedge clk);
    check(busy == 0, "R7 no late cycle", busy, 0);
    check(expQ.size() == 0, "R11 no stray writes", expQ.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule